// File: doc/BRIEF.md
# Stochastic OR adder with carry memory

This block adds two stochastic bitstreams, where each stream carries a probability as the fraction of cycles in which it is 1. A multiplexer adder halves its result. A plain OR gate loses a one whenever both inputs are high in the same cycle. This adder avoids both losses. It passes ones through like an OR gate. When both inputs are high, it counts the one that would be lost. It then pays that one back on the next cycle in which both inputs are low. The density of ones at the output therefore tracks the sum of the two input densities.

The output is combinational from the current inputs and the stored count, so it adds no cycle of delay to the stream. The count register changes on the rising clock edge. A clock enable freezes the adder and forces the output low. The block relies on the true sum of the input probabilities being at most 1, so that every stored one can eventually be paid back. If the count reaches the top of its range, it stays there and a sticky flag records that ones were lost.

Top module: `stoch_or_adder`

## Requirements
- R1: With enable high and exactly one input at 1, the output is 1 in that cycle and the pending count is unchanged after the clock edge.
- R2: With enable high, both inputs at 1 and the pending count below its maximum, the output is 1 and the count rises by one after the edge.
- R3: With enable high, both inputs at 0 and a pending count of zero, the output is 0 and the count stays zero.
- R4: With enable high, both inputs at 0 and a nonzero pending count, the output is 1 and the count falls by one after the edge.
- R5: With enable high, both inputs at 1 and the count at its maximum (all CNT_W bits set), the output is 1, the count holds its maximum and the overflow flag goes to 1 after the edge.
- R6: Once set, the overflow flag stays 1 until reset, whatever the inputs do.
- R7: While the synchronous reset is high, the output is 0, and after the edge the count is zero and the overflow flag is 0.
- R8: While enable is low and reset is low, the output is 0 and neither the count nor the overflow flag changes.
- R9: Over any enabled run without overflow that starts from a zero count, the number of output ones equals the number of input ones minus the pending count at the end.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Clock enable; when low, the output is 0 and the state holds |
| in_a | input | 1 | First stochastic input bit |
| in_b | input | 1 | Second stochastic input bit |
| sum_out | output | 1 | Stochastic sum bit, combinational |
| pending | output | CNT_W | Debug view of the stored ones still owed |
| overflow | output | 1 | Sticky flag, set when a one was lost at a full count |

## Verification
A wrong count shows at the ports within one cycle on the pending debug port. Without that port, it shows on sum_out at the first idle cycle: a count that was too low ends the payback early, and one that was too high emits a spurious one. A stuck or missing overflow flag shows directly on its own output. The bench therefore compares sum_out, pending and overflow on every driven cycle against a model built from the truth table. It also checks ones conservation over a long run of pseudo-random streams, which catches slow drift that a single cycle might hide.

// File: rtl/stoch_or_adder.sv
`timescale 1ns/1ps
module stoch_or_adder #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             in_a,
  input  logic             in_b,
  output logic             sum_out,
  output logic [CNT_W-1:0] pending,
  output logic             overflow
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] debt_q;
  logic             lost_q;

  wire both_hi  = in_a & in_b;
  wire both_lo  = ~in_a & ~in_b;
  wire has_debt = |debt_q;
  wire full     = (debt_q == CNT_MAX);

  assign sum_out  = en & ~rst & (in_a | in_b | has_debt);
  assign pending  = debt_q;
  assign overflow = lost_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      debt_q <= '0;
      lost_q <= 1'b0;
    end else if (en) begin
      if (both_hi) begin
        if (full) lost_q <= 1'b1;
        else      debt_q <= debt_q + 1'b1;
      end else if (both_lo && has_debt) begin
        debt_q <= debt_q - 1'b1;
      end
    end
  end
endmodule

// File: rtl/stoch_or_adder_chk.sv
`timescale 1ns/1ps
module stoch_or_adder_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             en,
  input logic             in_a,
  input logic             in_b,
  input logic             sum_out,
  input logic [CNT_W-1:0] pending,
  input logic             overflow
);
  localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

  // R1
  single_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (en && (in_a ^ in_b)) |-> sum_out);
  // R1
  single_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (en && (in_a ^ in_b)) |=> $stable(pending));
  // R2
  store_inc_chk: assert property (@(posedge clk) disable iff (rst)
    (en && in_a && in_b && pending != TOP) |=> (pending == $past(pending) + 1'b1));
  // R3
  idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (en && !in_a && !in_b && pending == '0) |-> !sum_out);
  // R4
  payback_out_chk: assert property (@(posedge clk) disable iff (rst)
    (en && !in_a && !in_b && pending != '0) |-> sum_out);
  // R4
  payback_dec_chk: assert property (@(posedge clk) disable iff (rst)
    (en && !in_a && !in_b && pending != '0) |=> (pending == $past(pending) - 1'b1));
  // R5
  saturate_chk: assert property (@(posedge clk) disable iff (rst)
    (en && in_a && in_b && pending == TOP) |=> (pending == TOP && overflow));
  // R6
  sticky_flag_chk: assert property (@(posedge clk) disable iff (rst)
    overflow |=> overflow);
  // R7
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (pending == '0 && !overflow));
  // R7
  reset_quiet_chk: assert property (@(posedge clk) rst |-> !sum_out);
  // R8
  gated_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !en |-> !sum_out);
  // R8
  gated_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> ($stable(pending) && $stable(overflow)));
endmodule

bind stoch_or_adder stoch_or_adder_chk #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/test_stoch_or_adder.sv
`timescale 1ns/1ps
module test_stoch_or_adder;
  localparam int W = 4;
  localparam logic [W-1:0] TOP = {W{1'b1}};

  typedef struct {
    logic       out;
    logic [W-1:0] cnt;
    logic       ovf;
    string      tag;
    bit         tally;
  } item_t;

  logic clk = 0, rst = 1, en = 0, in_a = 0, in_b = 0;
  logic sum_out, overflow;
  logic [W-1:0] pending;

  stoch_or_adder #(.CNT_W(W)) i_stoch_or_adder (
    .clk(clk), .rst(rst), .en(en), .in_a(in_a), .in_b(in_b),
    .sum_out(sum_out), .pending(pending), .overflow(overflow));

  always #10 clk = ~clk;

  item_t q[$];
  int checks = 0, fails = 0;
  int in_ones = 0, out_ones = 0;
  logic [W-1:0] m_cnt = '0;
  logic m_ovf = 0;

  task automatic check(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic drive(input logic ia, input logic ib, input logic ie, input logic ir,
                       input string tag, input bit tally);
    item_t it;
    @(negedge clk);
    in_a = ia; in_b = ib; en = ie; rst = ir;
    it.out = 0;
    if (ir) begin
      m_cnt = '0; m_ovf = 0;
    end else if (ie) begin
      if (tally) in_ones += int'(ia) + int'(ib);
      if (ia ^ ib) it.out = 1;
      else if (ia && ib) begin
        it.out = 1;
        if (m_cnt == TOP) m_ovf = 1; else m_cnt = m_cnt + 1'b1;
      end else if (m_cnt != '0) begin
        it.out = 1; m_cnt = m_cnt - 1'b1;
      end
    end
    it.cnt = m_cnt; it.ovf = m_ovf; it.tag = tag; it.tally = tally;
    q.push_back(it);
  endtask

  initial begin
    forever begin
      @(negedge clk);
      #8;
      if (q.size() > 0) begin
        item_t it;
        it = q.pop_front();
        check(it.tag, "sum_out", int'(sum_out), int'(it.out));
        if (it.tally) out_ones += int'(sum_out);
        @(posedge clk);
        #2;
        check(it.tag, "pending", int'(pending), int'(it.cnt));
        check(it.tag, "overflow", int'(overflow), int'(it.ovf));
      end
    end
  end

  initial begin
    #(20 * 200000);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [15:0] l1, l2;
    // R7 reset state
    drive(1, 1, 1, 1, "R7", 0);
    drive(0, 0, 0, 1, "R7", 0);
    // R3 idle with empty count
    drive(0, 0, 1, 0, "R3", 0);
    // R1 single input passes
    drive(1, 0, 1, 0, "R1", 0);
    drive(0, 1, 1, 0, "R1", 0);
    // R2 store two ones
    drive(1, 1, 1, 0, "R2", 0);
    drive(1, 1, 1, 0, "R2", 0);
    // R1 with debt pending: count unchanged
    drive(0, 1, 1, 0, "R1", 0);
    // R8 gated: output 0, state frozen, for every input pattern
    drive(1, 1, 0, 0, "R8", 0);
    drive(0, 0, 0, 0, "R8", 0);
    drive(1, 0, 0, 0, "R8", 0);
    // R4 payback then R3 idle
    drive(0, 0, 1, 0, "R4", 0);
    drive(0, 0, 1, 0, "R4", 0);
    drive(0, 0, 1, 0, "R3", 0);
    // R2 fill to the top, then R5 saturate
    for (int i = 0; i < 15; i++) drive(1, 1, 1, 0, "R2", 0);
    drive(1, 1, 1, 0, "R5", 0);
    drive(1, 1, 1, 0, "R5", 0);
    // R6 flag survives payback, idle and gating
    for (int i = 0; i < 15; i++) drive(0, 0, 1, 0, "R6", 0);
    drive(0, 0, 1, 0, "R6", 0);
    drive(1, 0, 0, 0, "R6", 0);
    // R7 reset clears the flag
    drive(1, 1, 1, 1, "R7", 0);
    drive(0, 0, 1, 0, "R3", 0);
    // R9 long run from pseudo-random streams, densities near 1/4 each
    l1 = 16'hACE1; l2 = 16'h3B07;
    in_ones = 0;
    for (int i = 0; i < 3000; i++) begin
      l1 = {l1[14:0], l1[15] ^ l1[13] ^ l1[12] ^ l1[10]};
      l2 = {l2[14:0], l2[15] ^ l2[14] ^ l2[12] ^ l2[3]};
      drive(l1[0] & l1[7], l2[2] & l2[11], (i % 50) > 2, 0, "R9", 1);
    end
    drive(0, 0, 0, 0, "R8", 0);
    repeat (4) @(posedge clk);
    @(negedge clk);
    // R9 conservation of ones
    check("R9", "overflow", int'(overflow), 0);
    check("R9", "out_ones", out_ones, in_ones - int'(pending));
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule